// File: doc/BRIEF.md
# Normalising Restoring Integer Divider

This block divides one unsigned integer by another over several clock cycles and returns the integer quotient. A request is made by raising `start` for one cycle with both operands valid. The block then works in two phases. First it slides the divisor left until its top operand bit is set, doubling a one-hot weight register with each slide. Then it runs a trial-subtract loop: whenever the running dividend can absorb the divisor, the difference replaces the dividend and the weight is added into the quotient. After each step the divisor and the weight both move right by one place. The loop stops when the weight has shifted out.

A divisor close to full scale therefore finishes in very few cycles, while a small divisor takes longer. A zero divisor would never normalise, so it is caught when the request is accepted and reported at once through an error flag. Operands are one bit narrower than the internal subtractor, so the trial difference always fits and its sign bit is a clean borrow.

Top module: `nrdiv_top`

## Requirements
- R1: After reset, `busy`, `done` and `errFlag` are low and `quotient` is zero.
- R2: For a nonzero divisor whose highest set bit is at position p, with s = (DATA_W-1) - p, `done` rises exactly 2*s+2 cycles after the clock edge that accepts `start`, and `quotient` then equals floor(dividend / divisor).
- R3: `busy` is high from the cycle after an accepted nonzero-divisor start until the cycle before `done`, and is low whenever `done` is high.
- R4: `done` is high for exactly one cycle per completed request.
- R5: With a zero divisor, `done` is high in the cycle after the accepted start, `errFlag` is 1, `quotient` is 0, and `busy` stays low.
- R6: An accepted start with a nonzero divisor clears `errFlag` in the next cycle.
- R7: `start` and the operands are ignored while `busy` is high: the running request finishes with its own result and timing.
- R8: While idle with no `start`, `quotient` and `errFlag` keep their last values, whatever the operand inputs do.
- R9: A `start` given in the cycle where `done` is high is accepted as a new request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, taken only when idle |
| dividend | input | DATA_W | Unsigned dividend |
| divisor | input | DATA_W | Unsigned divisor |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| errFlag | output | 1 | Last request had a zero divisor |
| quotient | output | DATA_W | Quotient of the last completed request |

## Verification
The result of a request is due a data-dependent number of cycles after it is accepted: 2*s+2 cycles for a nonzero divisor, where s is the number of left slides needed, and a single cycle for a zero divisor. The bench keeps its own count per request, derived from the divisor's leading bit position, and compares `busy`, `done` and `errFlag` on every falling edge, and `quotient` on every falling edge where the block is idle. Any early or late `done` therefore shows up in the exact cycle it occurs. Divisors with the top bit already set, a divisor of one, quotients of zero, back-to-back starts and starts during a busy phase are all covered.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NORM = 2'd1,
    ST_ITER = 2'd2
  } divState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic normShift;
    logic iterStep;
  } divCtrl_t;

endpackage

// File: rtl/nrdiv_datapath.sv
module nrdiv_datapath
  import nrdiv_pkg::*;
#(
  parameter int DATA_W = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  divCtrl_t          ctrl,
  input  logic [DATA_W-1:0] dividendIn,
  input  logic [DATA_W-1:0] divisorIn,
  output logic              divisorZero,
  output logic              divisorTopSet,
  output logic              weightLast,
  output logic [DATA_W-1:0] quotientOut
);

  localparam int SUB_W = DATA_W + 1;

  logic [DATA_W-1:0] remReg;
  logic [DATA_W-1:0] dvsReg;
  logic [DATA_W-1:0] weightReg;
  logic [DATA_W-1:0] quoReg;
  logic [SUB_W-1:0]  trialDiff;
  logic              borrow;

  assign trialDiff = {1'b0, remReg} - {1'b0, dvsReg};
  assign borrow    = trialDiff[SUB_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remReg    <= '0;
      dvsReg    <= '0;
      weightReg <= '0;
      quoReg    <= '0;
    end else if (ctrl.load) begin
      remReg    <= dividendIn;
      dvsReg    <= divisorIn;
      weightReg <= {{(DATA_W-1){1'b0}}, 1'b1};
      quoReg    <= '0;
    end else if (ctrl.normShift) begin
      dvsReg    <= dvsReg << 1;
      weightReg <= weightReg << 1;
    end else if (ctrl.iterStep) begin
      if (!borrow) begin
        remReg <= trialDiff[DATA_W-1:0];
        quoReg <= quoReg + weightReg;
      end
      dvsReg    <= dvsReg >> 1;
      weightReg <= weightReg >> 1;
    end
  end

  assign divisorZero   = (divisorIn == '0);
  assign divisorTopSet = dvsReg[DATA_W-1];
  assign weightLast    = weightReg[0];
  assign quotientOut   = quoReg;

endmodule

// File: rtl/nrdiv_control.sv
module nrdiv_control
  import nrdiv_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     divisorZero,
  input  logic     divisorTopSet,
  input  logic     weightLast,
  output divCtrl_t ctrl,
  output logic     busy,
  output logic     done,
  output logic     errFlag
);

  divState_t stateReg, stateNext;
  logic      doneNext;
  logic      errNext;

  always_comb begin
    stateNext = stateReg;
    ctrl      = '0;
    doneNext  = 1'b0;
    errNext   = errFlag;
    unique case (stateReg)
      ST_IDLE: begin
        if (start) begin
          ctrl.load = 1'b1;
          if (divisorZero) begin
            doneNext = 1'b1;
            errNext  = 1'b1;
          end else begin
            errNext   = 1'b0;
            stateNext = ST_NORM;
          end
        end
      end
      ST_NORM: begin
        if (divisorTopSet) stateNext = ST_ITER;
        else               ctrl.normShift = 1'b1;
      end
      ST_ITER: begin
        ctrl.iterStep = 1'b1;
        if (weightLast) begin
          stateNext = ST_IDLE;
          doneNext  = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateReg <= ST_IDLE;
      done     <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      stateReg <= stateNext;
      done     <= doneNext;
      errFlag  <= errNext;
    end
  end

  assign busy = (stateReg != ST_IDLE);

endmodule

// File: rtl/nrdiv_top.sv
module nrdiv_top
  import nrdiv_pkg::*;
#(
  parameter int DATA_W = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisor,
  output logic              busy,
  output logic              done,
  output logic              errFlag,
  output logic [DATA_W-1:0] quotient
);

  divCtrl_t ctrl;
  logic     divisorZero;
  logic     divisorTopSet;
  logic     weightLast;

  nrdiv_control u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .start         (start),
    .divisorZero   (divisorZero),
    .divisorTopSet (divisorTopSet),
    .weightLast    (weightLast),
    .ctrl          (ctrl),
    .busy          (busy),
    .done          (done),
    .errFlag       (errFlag)
  );

  nrdiv_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .ctrl          (ctrl),
    .dividendIn    (dividend),
    .divisorIn     (divisor),
    .divisorZero   (divisorZero),
    .divisorTopSet (divisorTopSet),
    .weightLast    (weightLast),
    .quotientOut   (quotient)
  );

endmodule

// File: rtl/nrdiv_checker.sv
module nrdiv_checker #(
  parameter int DATA_W = 31
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [DATA_W-1:0] divisor,
  input logic              busy,
  input logic              done,
  input logic              errFlag,
  input logic [DATA_W-1:0] quotient
);

  // R3
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R5
  zero_div_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && divisor == '0) |=> (done && errFlag && quotient == '0 && !busy));

  // R6
  err_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && divisor != '0) |=> (!errFlag && busy && !done));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(quotient) && $stable(errFlag)));

  // R4
  done_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> !done);

endmodule

bind nrdiv_top nrdiv_checker #(.DATA_W(DATA_W)) u_nrdiv_checker (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .divisor  (divisor),
  .busy     (busy),
  .done     (done),
  .errFlag  (errFlag),
  .quotient (quotient)
);

// File: tb/nrdiv_top_test.sv
module nrdiv_top_test;

  localparam int DATA_W     = 31;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [DATA_W-1:0] dividend = '0;
  logic [DATA_W-1:0] divisor = '0;
  logic              busy, done, errFlag;
  logic [DATA_W-1:0] quotient;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic              mBusy = 1'b0;
  logic              mDone = 1'b0;
  logic              mErr = 1'b0;
  logic [DATA_W-1:0] mQuo = '0;
  logic [DATA_W-1:0] mPending = '0;
  int                mCnt = 0;

  nrdiv_top #(.DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .errFlag(errFlag), .quotient(quotient)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int slideCount(input logic [DATA_W-1:0] b);
    int msb = 0;
    for (int i = 0; i < DATA_W; i++) if (b[i]) msb = i;
    return (DATA_W - 1) - msb;
  endfunction

  task automatic check(input logic ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference, one update per rising edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy <= 1'b0; mDone <= 1'b0; mErr <= 1'b0; mQuo <= '0; mCnt <= 0;
    end else begin
      mDone <= 1'b0;
      if (!mBusy && start) begin
        if (divisor == '0) begin
          mDone <= 1'b1; mErr <= 1'b1; mQuo <= '0;
        end else begin
          mBusy    <= 1'b1;
          mErr     <= 1'b0;
          mPending <= dividend / divisor;
          mCnt     <= 2 * slideCount(divisor) + 2;
        end
      end else if (mBusy) begin
        if (mCnt == 1) begin
          mBusy <= 1'b0; mDone <= 1'b1; mQuo <= mPending;
        end else begin
          mCnt <= mCnt - 1;
        end
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check(busy === mBusy, "R3", "busy", busy, mBusy);
      check(done === mDone, "R2/R4", "done", done, mDone);
      check(errFlag === mErr, "R6", "errFlag", errFlag, mErr);
      if (!mBusy)
        check(quotient === mQuo, "R8", "quotient", quotient, mQuo);
    end
  end

  task automatic waitDone();
    int guard = 0;
    while (!mDone && guard < 200) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic runOp(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b, input string tag);
    @(negedge clk);
    start = 1'b1; dividend = a; divisor = b;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    check(done === 1'b1, tag, "done seen", done, 1);
    if (b != 0)
      check(quotient === a / b, tag, "quotient", quotient, a / b);
    else
      check(errFlag === 1'b1 && quotient === '0, tag, "zero divisor result", quotient, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy === 1'b0 && done === 1'b0 && errFlag === 1'b0, "R1", "flags", {busy, done, errFlag}, 0);
    check(quotient === '0, "R1", "quotient", quotient, 0);

    runOp(31'd100, 31'd7, "R2");
    runOp(31'd0, 31'd5, "R2");
    runOp(31'd5, 31'd9, "R2");
    runOp(31'h7FFF_FFFF, 31'd1, "R2");
    runOp(31'd12345, 31'd12345, "R2");
    runOp(31'h7FFF_FFFF, 31'h4000_0000, "R2");
    runOp(31'h3FFF_FFFF, 31'h4000_0001, "R2");
    runOp(31'd77, 31'd0, "R5");
    runOp(31'd99, 31'd4, "R6");

    // R7: a second start mid-request with a zero divisor is ignored
    @(negedge clk);
    start = 1'b1; dividend = 31'd1000; divisor = 31'd3;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; dividend = 31'd55; divisor = 31'd0;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    check(quotient === 31'd333 && errFlag === 1'b0, "R7", "quotient after ignored start", quotient, 333);

    // R8: operands move while idle, no start
    repeat (4) begin
      @(negedge clk);
      dividend = $urandom; divisor = $urandom;
    end
    @(negedge clk);
    check(quotient === 31'd333, "R8", "idle quotient hold", quotient, 333);

    // R9: start held high, new request accepted in each done cycle
    @(negedge clk);
    start = 1'b1; dividend = 31'd900; divisor = 31'h2000_0000;
    repeat (20) @(negedge clk);
    start = 1'b0;
    waitDone();
    check(quotient === 31'd0, "R9", "back-to-back quotient", quotient, 0);

    for (int n = 0; n < 40; n++) begin
      logic [DATA_W-1:0] ra, rb;
      ra = $urandom;
      rb = $urandom >> ($urandom % 31);
      runOp(ra, rb, "R2");
    end

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule